// File: doc/BRIEF.md
# Double-Buffered Count-Down PWM Timer

This block generates pulse-width modulated outputs from one shared down-counter. The counter starts at an active period value, counts down to zero, and then reloads. Each channel compares the count with its own active threshold. Its output is high while the count is non-zero and at or below the threshold, and low otherwise. Every channel drives its output from a register, and all channels switch on the same clock edge.

Software writes the period, the per-channel thresholds and a per-channel inversion mask through a simple write port. These writes land in shadow copies. The active copies are replaced together, and only on the clock edge that leaves the zero count. A commit happens only if a threshold write has arrived since the last commit. Software therefore writes the period first and a threshold last, and the hardware never applies a mixed old/new pair. A channel in inversion mode flips its polarity at every period boundary.

A one-clock zero flag and the live count are exported so that software can time its updates.

Top module: `pwm_dbuf`

## Requirements
- R1: The count falls by one on every clock while non-zero. From zero it reloads to the active period value P on the next clock, so a period lasts P+1 clocks.
- R2: A channel with active threshold C and no inversion is high in exactly the counts 1..min(C,P) and low in the zero count. It has min(C,P) high clocks per period: C=0 gives none, and C>=P gives high in every non-zero count.
- R3: `zero_o` is high in exactly the clocks where `cnt_o` is zero, which is once per period.
- R4: Write address map: 0 = period; k+1 = threshold of channel k (k from 0 to NUM_CH-1); NUM_CH+1 = inversion mask, with bit k of the data belonging to channel k. Writes to any higher address have no effect.
- R5: Writes change only the shadow copies. A write in the middle of a period leaves the length and the high time of that period unchanged, and the new values apply from the next period.
- R6: Shadow values are committed at the zero count only if a threshold write has occurred since the last commit. A period write on its own changes nothing until a threshold write follows it.
- R7: While a channel's inversion bit is active, its output is complemented in every other period, and the phase changes only at the period boundary. Over two consecutive periods the high counts are min(C,P) and P+1-min(C,P), in either order.
- R8: During reset and directly after it, the count is 0, `zero_o` is 1, all outputs are 0, and all active and shadow values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| pwm_o | output | NUM_CH | PWM outputs, one per channel |
| zero_o | output | 1 | High while the count is zero |
| cnt_o | output | CNT_W | Current count |

## Verification
A fault in the active copies or the pending flag appears at the ports within one period: it shows up as a wrong period length or a wrong number of high clocks, measured between two `zero_o` pulses. A premature commit appears in the same period as the write, as a shortened remainder of that period. A phase error shows up when two consecutive periods have the wrong pair of high counts. A counter fault appears within one clock as a step in `cnt_o` that is not a decrement.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  typedef enum logic [1:0] {
    REG_PERIOD,
    REG_THRESH,
    REG_INVERT,
    REG_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input int unsigned addr, input int unsigned num_ch);
    if (addr == 0) return REG_PERIOD;
    else if (addr <= num_ch) return REG_THRESH;
    else if (addr == num_ch + 1) return REG_INVERT;
    else return REG_NONE;
  endfunction

endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [CNT_W-1:0]              wr_data_i,
  input  logic                          at_zero_i,
  output logic [CNT_W-1:0]              period_act_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  thresh_act_o,
  output logic [NUM_CH-1:0]             inv_act_o,
  output logic [CNT_W-1:0]              period_nxt_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  thresh_nxt_o,
  output logic [NUM_CH-1:0]             inv_nxt_o,
  output logic                          pending_o
);

  logic [CNT_W-1:0]             period_sh, period_act;
  logic [NUM_CH-1:0][CNT_W-1:0] thresh_sh, thresh_act;
  logic [NUM_CH-1:0]            inv_sh, inv_act;
  logic                         pending_q;
  logic                         commit;
  reg_sel_e                     sel;

  assign sel    = decode_addr(int'(wr_addr_i), NUM_CH);
  assign commit = at_zero_i & pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_sh <= '0;
      thresh_sh <= '0;
      inv_sh    <= '0;
    end else if (wr_en_i) begin
      if (sel == REG_PERIOD) period_sh <= wr_data_i;
      if (sel == REG_INVERT) inv_sh <= wr_data_i[NUM_CH-1:0];
      for (int k = 0; k < NUM_CH; k++) begin
        if (sel == REG_THRESH && wr_addr_i == ADDR_W'(k + 1)) thresh_sh[k] <= wr_data_i;
      end
    end
  end

  // a threshold write landing on the commit edge keeps the request alive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= 1'b0;
    else if (wr_en_i && sel == REG_THRESH) pending_q <= 1'b1;
    else if (commit) pending_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_act <= '0;
      thresh_act <= '0;
      inv_act    <= '0;
    end else if (commit) begin
      period_act <= period_sh;
      thresh_act <= thresh_sh;
      inv_act    <= inv_sh;
    end
  end

  assign period_nxt_o = commit ? period_sh : period_act;
  assign thresh_nxt_o = commit ? thresh_sh : thresh_act;
  assign inv_nxt_o    = commit ? inv_sh    : inv_act;
  assign period_act_o = period_act;
  assign thresh_act_o = thresh_act;
  assign inv_act_o    = inv_act;
  assign pending_o    = pending_q;

endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_nxt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             at_zero_o
);

  logic [CNT_W-1:0] cnt_q;

  assign at_zero_o = (cnt_q == '0);
  assign cnt_nxt_o = at_zero_o ? period_nxt_i : cnt_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             at_zero_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] thresh_nxt_i,
  input  logic             inv_nxt_i,
  output logic             pwm_o,
  output logic             phase_o
);

  logic phase_q, phase_d, level_d, pwm_q;

  // phase moves only on the reload edge, so the flip lands on the period boundary
  always_comb begin
    phase_d = phase_q;
    if (at_zero_i) phase_d = inv_nxt_i ? ~phase_q : 1'b0;
  end

  assign level_d = (cnt_nxt_i != '0) && (cnt_nxt_i <= thresh_nxt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      pwm_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pwm_q   <= level_d ^ phase_d;
    end
  end

  assign pwm_o   = pwm_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ADDR_W = $clog2(NUM_CH + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              zero_o,
  output logic [CNT_W-1:0]  cnt_o
);

  logic [CNT_W-1:0]             period_act, period_nxt;
  logic [NUM_CH-1:0][CNT_W-1:0] thresh_act, thresh_nxt;
  logic [NUM_CH-1:0]            inv_act, inv_nxt;
  logic [NUM_CH-1:0]            phase;
  logic                         pending;
  logic [CNT_W-1:0]             cnt_q, cnt_nxt;
  logic                         at_zero;

  pwm_shadow_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .at_zero_i    (at_zero),
    .period_act_o (period_act),
    .thresh_act_o (thresh_act),
    .inv_act_o    (inv_act),
    .period_nxt_o (period_nxt),
    .thresh_nxt_o (thresh_nxt),
    .inv_nxt_o    (inv_nxt),
    .pending_o    (pending)
  );

  pwm_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_nxt_i (period_nxt),
    .cnt_o        (cnt_q),
    .cnt_nxt_o    (cnt_nxt),
    .at_zero_o    (at_zero)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    pwm_chan_out #(.CNT_W(CNT_W)) u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .at_zero_i    (at_zero),
      .cnt_nxt_i    (cnt_nxt),
      .thresh_nxt_i (thresh_nxt[k]),
      .inv_nxt_i    (inv_nxt[k]),
      .pwm_o        (pwm_o[k]),
      .phase_o      (phase[k])
    );
  end

  assign zero_o = at_zero;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 3
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [CNT_W-1:0]             cnt_i,
  input logic [CNT_W-1:0]             period_act_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] thresh_act_i,
  input logic [NUM_CH-1:0]            inv_act_i,
  input logic [NUM_CH-1:0]            phase_i,
  input logic                         pending_i,
  input logic [NUM_CH-1:0]            pwm_i
);

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |=> (cnt_i == CNT_W'($past(cnt_i) - 1'b1))); // R1

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> (cnt_i == period_act_i)); // R1

  AST_HOLD_MIDCYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |=> ($stable(period_act_i) && $stable(thresh_act_i) && $stable(inv_act_i))); // R5

  AST_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0 && !pending_i) |=> ($stable(period_act_i) && $stable(thresh_act_i))); // R6

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    AST_LOW_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i == '0 && !phase_i[k]) |-> !pwm_i[k]); // R2

    AST_HIGH_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i != '0 && cnt_i <= thresh_act_i[k]) |-> (pwm_i[k] != phase_i[k])); // R2

    AST_PHASE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i != '0) |=> $stable(phase_i[k])); // R7
  end

endmodule

bind pwm_dbuf pwm_dbuf_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnt_i        (cnt_q),
  .period_act_i (period_act),
  .thresh_act_i (thresh_act),
  .inv_act_i    (inv_act),
  .phase_i      (phase),
  .pending_i    (pending),
  .pwm_i        (pwm_o)
);

// File: tb/pwm_dbuf_test.sv
module pwm_dbuf_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int NUM_CH     = 3;
  localparam int ADDR_W     = $clog2(NUM_CH + 2);
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 6;
  // period, thr0, thr1, thr2, invert mask
  localparam int VEC [NVEC][5] = '{
    '{4, 2, 0, 4, 0},
    '{7, 3, 9, 7, 1},
    '{1, 1, 0, 2, 6},
    '{10, 5, 1, 10, 7},
    '{3, 0, 0, 0, 2},
    '{12, 11, 12, 13, 4}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic [NUM_CH-1:0] pwm;
  logic              zero;
  logic [CNT_W-1:0]  cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_dbuf #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .pwm_o     (pwm),
    .zero_o    (zero),
    .cnt_o     (cnt)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(a);
    wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic sync_start();
    while (!zero) @(negedge clk);
    @(negedge clk);
  endtask

  // counts clocks and high clocks up to and including the next zero count
  task automatic run_period(output int len, output int hi [NUM_CH], output bit zbad);
    bit fin = 1'b0;
    len = 0;
    zbad = 1'b0;
    for (int k = 0; k < NUM_CH; k++) hi[k] = 0;
    while (!fin) begin
      len++;
      for (int k = 0; k < NUM_CH; k++) hi[k] += int'(pwm[k]);
      if (zero != (cnt == '0)) zbad = 1'b1;
      if (zero) fin = 1'b1;
      @(negedge clk);
    end
  endtask

  function automatic int min_hi(input int p, input int c);
    return (c < p) ? c : p;
  endfunction

  initial begin
    int len1, len2, p, m;
    int h1 [NUM_CH];
    int h2 [NUM_CH];
    bit z1, z2;

    // R8 reset state
    #(CLK_PERIOD / 4);
    check(cnt == '0, "R8", "cnt in reset", int'(cnt), 0);
    check(zero == 1'b1, "R8", "zero in reset", int'(zero), 1);
    check(pwm == '0, "R8", "pwm in reset", int'(pwm), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cnt == '0 && pwm == '0, "R8", "idle after reset", int'(cnt), 0);

    // table walk: R1 R2 R3 R7
    for (int v = 0; v < NVEC; v++) begin
      p = VEC[v][0];
      wr(NUM_CH + 1, VEC[v][4]);
      wr(0, p);
      wr(3, VEC[v][3]);
      wr(2, VEC[v][2]);
      wr(1, VEC[v][1]);
      sync_start();
      check(int'(cnt) == p, "R1", "count at period start", int'(cnt), p);
      run_period(len1, h1, z1);
      run_period(len2, h2, z2);
      check(len1 == p + 1 && len2 == p + 1, "R1", "period length", len1, p + 1);
      check(!z1 && !z2, "R3", "zero flag vs count", int'(z1) + int'(z2), 0);
      for (int k = 0; k < NUM_CH; k++) begin
        m = min_hi(p, VEC[v][k + 1]);
        if (VEC[v][4][k]) begin
          check((h1[k] == m && h2[k] == p + 1 - m) || (h1[k] == p + 1 - m && h2[k] == m),
                "R7", "inverted period pair", h1[k] + 1000 * h2[k], m + 1000 * (p + 1 - m));
        end else begin
          check(h1[k] == m && h2[k] == m, "R2", "high clocks per period", h1[k], m);
        end
      end
    end

    // R5 mid-period write does not touch the running period
    wr(NUM_CH + 1, 0);
    wr(0, 7);
    wr(1, 3);
    sync_start();
    sync_start();
    check(int'(cnt) == 7, "R5", "start count", int'(cnt), 7);
    @(negedge clk);
    @(negedge clk);
    wr(0, 5);
    wr(1, 2);
    run_period(len1, h1, z1);
    check(len1 == 4, "R5", "remainder length after write", len1, 4);
    check(h1[0] == 3, "R5", "remainder high clocks", h1[0], 3);
    run_period(len2, h2, z2);
    check(len2 == 6 && h2[0] == 2, "R5", "next period uses new pair", len2 * 100 + h2[0], 602);

    // R6 period write alone stays pending; R4 unmapped address ignored
    wr(0, 9);
    wr(7, 3);
    sync_start();
    run_period(len1, h1, z1);
    run_period(len2, h2, z2);
    check(len1 == 6 && len2 == 6, "R6", "no commit without threshold write", len1, 6);
    check(h1[0] == 2 && h2[0] == 2, "R4", "unmapped write ignored", h1[0], 2);
    wr(1, 2);
    sync_start();
    check(int'(cnt) == 9, "R6", "commit after threshold write", int'(cnt), 9);
    run_period(len1, h1, z1);
    check(len1 == 10 && h1[0] == 2, "R6", "committed period", len1 * 100 + h1[0], 1002);

    // R8 reset in the middle of a run clears shadow values too
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(cnt == '0 && zero && pwm == '0, "R8", "state under reset", int'(cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    wr(1, 1);
    repeat (3) @(negedge clk);
    check(cnt == '0 && pwm == '0, "R8", "shadow period cleared", int'(cnt), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule